// File: doc/BRIEF.md
# Nibble-Wide Call Stack Frame Engine

This block carries out the stack half of register-pair pushes and pops, bank-select saves and restores, subroutine calls and returns for a 4-bit microcontroller. The stack sits in a 512-nibble data memory, grows toward lower addresses, and is addressed by an 8-bit stack pointer plus a stack-bank bit that picks one of the two 256-nibble halves. A command is accepted while the engine is idle. The engine then moves one nibble per clock through a synchronous single-port memory interface, updates the stack pointer, and pulses a completion strobe. Popped values and restored program-counter and flag bits are presented together with that strobe.

Calls and returns use one of two frame layouts, chosen per command by a mode input. The compact layout spends 4 nibbles on the 14-bit program counter and the two bank-enable flags. The extended layout spends 6 nibbles: it keeps the upper PC bits in a nibble of their own and the flags in another, and it skips the nibble just below the stack pointer. In both layouts the nibbles are placed out of address order, and a return walks the same slots back.

Top module: `stack_frame_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the stack pointer becomes 0 and the sequencer returns to idle. After reset, `sp`=0, `busy`=0, `done`=0 and `memEn`=0.
- R2: Op code 0 pushes `pairIn`: bits 7:4 go to SP-1 and bits 3:0 go to SP-2, then SP drops by 2. Op code 1 pops a pair: `popPair[7:4]` is read from SP+1 and `popPair[3:0]` from SP, then SP rises by 2.
- R3: Op code 2 writes `mbsIn` to SP-1 and {2'b00,`rbsIn`} to SP-2, then SP drops by 2. Op code 3 restores `popMbs` from SP+1 and `popRbs` from bits 1:0 of SP, then SP rises by 2.
- R4: Op code 4 with `frameMode`=0 is a compact call. It writes PC[7:4] to SP-1, PC[3:0] to SP-2, {MBE,RBE,PC[13],PC[12]} (MBE in bit 3) to SP-3 and PC[11:8] to SP-4, then SP drops by 4.
- R5: Op code 4 with `frameMode`=1 is an extended call. It writes {2'b00,MBE,RBE} to SP-2, PC[7:4] to SP-3, PC[3:0] to SP-4, {2'b00,PC[13:12]} to SP-5 and PC[11:8] to SP-6, then SP drops by 6. SP-1 is not written.
- R6: Op code 5 is a return. It reads back the frame of the mode given with it, presents the whole PC on `retPc` and the flags on `retMbe`/`retRbe`, and raises SP by 4 (compact) or 6 (extended).
- R7: A command moving n nibbles keeps `busy` high for exactly n+1 cycles and performs one memory access per cycle. `done` is high for exactly the one cycle after `busy` falls. `sp` and the result outputs are valid during that cycle, and `sp` changes at no other time.
- R8: Op codes 6 and 7, and any command presented while `busy` is high, are ignored: no access, no `busy`, no change of `sp`.
- R9: The stack pointer and all frame addresses wrap modulo 256. A push from SP=0 writes addresses 255 and 254 and leaves SP=254.
- R10: `memAddr` is {`stackBank`, 8-bit slot address}, with `stackBank` sampled when the command is accepted. Read data is taken from `memRdata` one cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 3 | Op code 0..5, see R2-R6 |
| frameMode | input | 1 | 0 compact call frame, 1 extended call frame |
| stackBank | input | 1 | Memory half holding the stack |
| pcIn | input | 14 | Program counter to save on a call |
| mbeIn | input | 1 | Memory-bank enable flag to save |
| rbeIn | input | 1 | Register-bank enable flag to save |
| pairIn | input | 8 | Register pair to push |
| mbsIn | input | 4 | Memory-bank select to push |
| rbsIn | input | 2 | Register-bank select to push |
| memEn | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | 9 | Nibble address |
| memWdata | output | 4 | Write nibble |
| memRdata | input | 4 | Read nibble, one cycle after the read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp | output | 8 | Stack pointer |
| popPair | output | 8 | Popped register pair |
| popMbs | output | 4 | Restored memory-bank select |
| popRbs | output | 2 | Restored register-bank select |
| retPc | output | 14 | Restored program counter |
| retMbe | output | 1 | Restored memory-bank enable |
| retRbe | output | 1 | Restored register-bank enable |

## Verification
The hardest case to reach from the ports is a second command that arrives while a frame is still being written. The driver holds `cmdValid` high with a different op code for one cycle inside the busy window. The scoreboard then expects exactly one completion, the first command's stack pointer and an unchanged memory. The extended call is also hard to observe: the nibble just below the stack pointer is left out of that frame. The bench fills that nibble with a marker value before the call and reads it back from its own memory model afterwards.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    OP_PUSH_PAIR = 3'd0,
    OP_POP_PAIR  = 3'd1,
    OP_PUSH_BANK = 3'd2,
    OP_POP_BANK  = 3'd3,
    OP_CALL      = 3'd4,
    OP_RET       = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    SL_PAIR_HI, SL_PAIR_LO, SL_MBS, SL_RBS,
    SL_PC_HI, SL_PC_MID, SL_PC_LO, SL_TOP_FLAGS, SL_TOP, SL_FLAGS
  } slot_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       load;      // latch operands
    logic       access;    // memory access this cycle
    logic       write;     // access direction
    logic [2:0] wk;        // slot distance below the pre-push SP
    logic [2:0] delta;     // frame size in nibbles
    slot_e      slot;      // nibble moved this cycle
    logic       capture;   // read data of previous cycle is valid
    slot_e      capSlot;   // slot of that read data
    logic       spUpdate;  // apply delta to SP
    logic       spDown;    // push direction
  } strobe_t;
endpackage

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic          frameMode,
  output strobe_t       stb,
  output logic          busy,
  output logic          done
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e     state;
  logic [2:0] opQ;
  logic       longQ;
  logic [2:0] stepCnt;
  slot_e      prevSlot;
  logic       doneQ;

  logic       accept;
  logic [1:0] kind;      // 0 pair, 1 bank, 2 call/return
  logic       isPush;
  logic       longCall;
  logic [2:0] nSteps;
  logic [2:0] wk;
  slot_e      curSlot;

  function automatic slot_e slotFor(input logic [1:0] k, input logic lng, input logic [2:0] d);
    slot_e s;
    s = SL_PC_HI;
    case (k)
      2'd0:    s = (d == 3'd1) ? SL_PAIR_HI : SL_PAIR_LO;
      2'd1:    s = (d == 3'd1) ? SL_MBS : SL_RBS;
      default: begin
        if (!lng) begin
          case (d)
            3'd1:    s = SL_PC_MID;
            3'd2:    s = SL_PC_LO;
            3'd3:    s = SL_TOP_FLAGS;
            default: s = SL_PC_HI;
          endcase
        end else begin
          case (d)
            3'd2:    s = SL_FLAGS;
            3'd3:    s = SL_PC_MID;
            3'd4:    s = SL_PC_LO;
            3'd5:    s = SL_TOP;
            default: s = SL_PC_HI;
          endcase
        end
      end
    endcase
    return s;
  endfunction

  assign accept   = (state == ST_IDLE) && cmdValid && (cmdOp <= 3'd5);
  assign kind     = opQ[2] ? 2'd2 : (opQ[1] ? 2'd1 : 2'd0);
  assign isPush   = ~opQ[0];
  assign longCall = (kind == 2'd2) && longQ;
  assign nSteps   = (kind == 2'd2) ? (longQ ? 3'd5 : 3'd4) : 3'd2;
  assign wk       = stepCnt + 3'd1 + {2'b00, longCall};
  assign curSlot  = slotFor(kind, longQ, wk);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      opQ      <= 3'd0;
      longQ    <= 1'b0;
      stepCnt  <= 3'd0;
      prevSlot <= SL_PAIR_HI;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= (state == ST_FIN);
      case (state)
        ST_IDLE: if (accept) begin
          opQ     <= cmdOp;
          longQ   <= frameMode;
          stepCnt <= 3'd0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          prevSlot <= curSlot;
          stepCnt  <= stepCnt + 3'd1;
          if (stepCnt == nSteps - 3'd1) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load     = accept;
    stb.access   = (state == ST_RUN);
    stb.write    = isPush;
    stb.wk       = wk;
    stb.delta    = (kind == 2'd2) ? (longQ ? 3'd6 : 3'd4) : 3'd2;
    stb.slot     = curSlot;
    stb.capture  = !isPush && (((state == ST_RUN) && (stepCnt != 3'd0)) || (state == ST_FIN));
    stb.capSlot  = prevSlot;
    stb.spUpdate = (state == ST_FIN);
    stb.spDown   = isPush;
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_ignore_busy_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(opQ));
  p_bad_op_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && cmdValid && (cmdOp > 3'd5)) |=> (state == ST_IDLE));
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int SP_W   = 8,
  parameter int ADDR_W = 9,
  parameter int PC_W   = 14,
  localparam int BANK_W = ADDR_W - SP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [BANK_W-1:0] stackBank,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              mbeIn,
  input  logic              rbeIn,
  input  logic [2*NIB_W-1:0] pairIn,
  input  logic [NIB_W-1:0]  mbsIn,
  input  logic [1:0]        rbsIn,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NIB_W-1:0]  memWdata,
  input  logic [NIB_W-1:0]  memRdata,
  output logic [SP_W-1:0]   sp,
  output logic [2*NIB_W-1:0] popPair,
  output logic [NIB_W-1:0]  popMbs,
  output logic [1:0]        popRbs,
  output logic [PC_W-1:0]   retPc,
  output logic              retMbe,
  output logic              retRbe
);
  logic [BANK_W-1:0]  bankQ;
  logic [PC_W-1:0]    pcQ;
  logic               mbeQ, rbeQ;
  logic [2*NIB_W-1:0] pairQ;
  logic [NIB_W-1:0]   mbsQ;
  logic [1:0]         rbsQ;
  logic [SP_W-1:0]    slotAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankQ <= '0; pcQ <= '0; mbeQ <= 1'b0; rbeQ <= 1'b0;
      pairQ <= '0; mbsQ <= '0; rbsQ <= '0;
    end else if (stb.load) begin
      bankQ <= stackBank; pcQ <= pcIn; mbeQ <= mbeIn; rbeQ <= rbeIn;
      pairQ <= pairIn; mbsQ <= mbsIn; rbsQ <= rbsIn;
    end
  end

  // pushes count down from SP, pops count up from the frame base
  assign slotAddr = stb.write ? (sp - SP_W'(stb.wk))
                              : (sp + SP_W'(stb.delta - stb.wk));
  assign memEn    = stb.access;
  assign memWe    = stb.access && stb.write;
  assign memAddr  = {bankQ, slotAddr};

  always_comb begin
    case (stb.slot)
      SL_PAIR_HI:   memWdata = pairQ[2*NIB_W-1:NIB_W];
      SL_PAIR_LO:   memWdata = pairQ[NIB_W-1:0];
      SL_MBS:       memWdata = mbsQ;
      SL_RBS:       memWdata = {2'b00, rbsQ};
      SL_PC_HI:     memWdata = pcQ[11:8];
      SL_PC_MID:    memWdata = pcQ[7:4];
      SL_PC_LO:     memWdata = pcQ[3:0];
      SL_TOP_FLAGS: memWdata = {mbeQ, rbeQ, pcQ[13:12]};
      SL_TOP:       memWdata = {2'b00, pcQ[13:12]};
      default:      memWdata = {2'b00, mbeQ, rbeQ};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0; popPair <= '0; popMbs <= '0; popRbs <= '0;
      retPc <= '0; retMbe <= 1'b0; retRbe <= 1'b0;
    end else begin
      if (stb.spUpdate)
        sp <= stb.spDown ? (sp - SP_W'(stb.delta)) : (sp + SP_W'(stb.delta));
      if (stb.capture) begin
        case (stb.capSlot)
          SL_PAIR_HI:   popPair[2*NIB_W-1:NIB_W] <= memRdata;
          SL_PAIR_LO:   popPair[NIB_W-1:0] <= memRdata;
          SL_MBS:       popMbs <= memRdata;
          SL_RBS:       popRbs <= memRdata[1:0];
          SL_PC_HI:     retPc[11:8] <= memRdata;
          SL_PC_MID:    retPc[7:4] <= memRdata;
          SL_PC_LO:     retPc[3:0] <= memRdata;
          SL_TOP_FLAGS: begin
            retMbe <= memRdata[3]; retRbe <= memRdata[2]; retPc[13:12] <= memRdata[1:0];
          end
          SL_TOP:       retPc[13:12] <= memRdata[1:0];
          default: begin
            retMbe <= memRdata[1]; retRbe <= memRdata[0];
          end
        endcase
      end
    end
  end

  p_sp_only_on_update_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (sp != $past(sp))) |-> $past(stb.spUpdate));
endmodule

// File: rtl/stack_frame_engine.sv
module stack_frame_engine
  import sfe_pkg::*;
#(
  parameter int SP_W   = 8,
  parameter int ADDR_W = 9,
  parameter int PC_W   = 14,
  localparam int BANK_W = ADDR_W - SP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              frameMode,
  input  logic [BANK_W-1:0] stackBank,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              mbeIn,
  input  logic              rbeIn,
  input  logic [7:0]        pairIn,
  input  logic [3:0]        mbsIn,
  input  logic [1:0]        rbsIn,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memWdata,
  input  logic [3:0]        memRdata,
  output logic              busy,
  output logic              done,
  output logic [SP_W-1:0]   sp,
  output logic [7:0]        popPair,
  output logic [3:0]        popMbs,
  output logic [1:0]        popRbs,
  output logic [PC_W-1:0]   retPc,
  output logic              retMbe,
  output logic              retRbe
);
  strobe_t stb;

  sfe_ctrl ctrl_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .frameMode(frameMode), .stb(stb), .busy(busy), .done(done)
  );

  sfe_datapath #(.SP_W(SP_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .stackBank(stackBank),
    .pcIn(pcIn), .mbeIn(mbeIn), .rbeIn(rbeIn), .pairIn(pairIn),
    .mbsIn(mbsIn), .rbsIn(rbsIn),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .sp(sp), .popPair(popPair), .popMbs(popMbs),
    .popRbs(popRbs), .retPc(retPc), .retMbe(retMbe), .retRbe(retRbe)
  );

  p_mem_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    memEn |-> busy);
endmodule

// File: tb/stack_frame_engine_tb_top.sv
`timescale 1ns/1ps
module stack_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic        frameMode = 1'b0;
  logic [0:0]  stackBank = 1'b0;
  logic [13:0] pcIn = '0;
  logic        mbeIn = 1'b0, rbeIn = 1'b0;
  logic [7:0]  pairIn = '0;
  logic [3:0]  mbsIn = '0;
  logic [1:0]  rbsIn = '0;
  logic        memEn, memWe;
  logic [8:0]  memAddr;
  logic [3:0]  memWdata;
  logic [3:0]  memRdata;
  logic        busy, done;
  logic [7:0]  sp, popPair;
  logic [3:0]  popMbs;
  logic [1:0]  popRbs;
  logic [13:0] retPc;
  logic        retMbe, retRbe;

  always #10 clk = ~clk;  // 50 MHz

  stack_frame_engine dut_i (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .frameMode(frameMode),
    .stackBank(stackBank), .pcIn(pcIn), .mbeIn(mbeIn), .rbeIn(rbeIn), .pairIn(pairIn),
    .mbsIn(mbsIn), .rbsIn(rbsIn), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .busy(busy), .done(done), .sp(sp),
    .popPair(popPair), .popMbs(popMbs), .popRbs(popRbs), .retPc(retPc),
    .retMbe(retMbe), .retRbe(retRbe)
  );

  // bench-side nibble memory with one-cycle read latency
  logic [3:0] mem [512];
  logic       pokeEn = 1'b0;
  logic [8:0] pokeAddr = '0;
  logic [3:0] pokeData = '0;
  always @(posedge clk) begin
    if (pokeEn) mem[pokeAddr] <= pokeData;
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  typedef struct {
    int         op;
    logic [7:0] sp;
    logic [7:0] pair;
    logic [3:0] mbs;
    logic [1:0] rbs;
    logic [13:0] pc;
    logic       mbe;
    logic       rbe;
    string      req;
  } exp_t;
  exp_t q[$];
  exp_t mon;

  function automatic exp_t mkExp(input int op, input logic [7:0] s, input string req);
    exp_t e;
    e.op = op; e.sp = s; e.pair = '0; e.mbs = '0; e.rbs = '0;
    e.pc = '0; e.mbe = 1'b0; e.rbe = 1'b0; e.req = req;
    return e;
  endfunction

  // monitor: compare each completion against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        chk("R8 unexpected completion", 1, 0);
      end else begin
        mon = q.pop_front();
        chk({mon.req, " sp"}, sp, mon.sp);
        case (mon.op)
          1: chk({mon.req, " popPair"}, popPair, mon.pair);
          3: begin
            chk({mon.req, " popMbs"}, popMbs, mon.mbs);
            chk({mon.req, " popRbs"}, popRbs, mon.rbs);
          end
          5: begin
            chk({mon.req, " retPc"}, retPc, mon.pc);
            chk({mon.req, " retMbe"}, retMbe, mon.mbe);
            chk({mon.req, " retRbe"}, retRbe, mon.rbe);
          end
          default: ;
        endcase
      end
    end
  end

  // driver: queue the expectation, issue the command, time the busy window
  task automatic issue(input logic [2:0] op, input logic lng, input logic bank,
                       input int nibbles, input exp_t e, input bit interfere);
    int cnt;
    q.push_back(e);
    @(negedge clk);
    cmdOp = op; frameMode = lng; stackBank = bank; cmdValid = 1'b1;
    @(negedge clk);
    if (interfere) begin
      cmdOp = 3'd1; frameMode = ~lng;   // second command inside the busy window
    end else cmdValid = 1'b0;
    cnt = 0;
    while (busy && cnt < 20) begin
      cnt++;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    chk("R7 busy cycles", cnt, nibbles + 1);
    chk("R7 done after busy", done, 1);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  task automatic poke(input logic [8:0] a, input logic [3:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  initial begin
    exp_t e;
    for (int i = 0; i < 512; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset sp", sp, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset memEn", memEn, 0);

    // R2 / R9: push pair from SP=0 wraps to 255/254
    pairIn = 8'hB7;
    issue(3'd0, 1'b0, 1'b0, 2, mkExp(0, 8'd254, "R2 push pair"), 0);
    chk("R9 wrap hi nibble at 255", mem[255], 4'hB);
    chk("R2 lo nibble at 254", mem[254], 4'h7);
    e = mkExp(1, 8'd0, "R2 pop pair"); e.pair = 8'hB7;
    issue(3'd1, 1'b0, 1'b0, 2, e, 0);

    // R3 / R10: bank selects in the upper memory half
    mbsIn = 4'hF; rbsIn = 2'd2;
    issue(3'd2, 1'b0, 1'b1, 2, mkExp(2, 8'd254, "R3 push bank"), 0);
    chk("R10 mbs at bank1 slot 255", mem[9'h1FF], 4'hF);
    chk("R10 rbs at bank1 slot 254", mem[9'h1FE], 4'h2);
    chk("R10 bank0 untouched", mem[9'h0FE], 4'h7);
    mbsIn = 4'h0; rbsIn = 2'd0;
    e = mkExp(3, 8'd0, "R3 pop bank"); e.mbs = 4'hF; e.rbs = 2'd2;
    issue(3'd3, 1'b0, 1'b1, 2, e, 0);

    // move SP to 254 with a known pair
    pairIn = 8'h3C;
    issue(3'd0, 1'b0, 1'b0, 2, mkExp(0, 8'd254, "R2 push pair 3C"), 0);

    // R4: compact call
    pcIn = 14'h29C3; mbeIn = 1'b1; rbeIn = 1'b0;
    issue(3'd4, 1'b0, 1'b0, 4, mkExp(4, 8'd250, "R4 compact call"), 0);
    chk("R4 PC[7:4] at SP-1", mem[253], 4'hC);
    chk("R4 PC[3:0] at SP-2", mem[252], 4'h3);
    chk("R4 flags+PC top at SP-3", mem[251], 4'hA);
    chk("R4 PC[11:8] at SP-4", mem[250], 4'h9);
    pcIn = '0; mbeIn = 1'b0;
    e = mkExp(5, 8'd254, "R6 compact return"); e.pc = 14'h29C3; e.mbe = 1'b1; e.rbe = 1'b0;
    issue(3'd5, 1'b0, 1'b0, 4, e, 0);

    // R5: extended call; SP-1 holds a marker that must survive
    poke(9'd253, 4'h6);
    pcIn = 14'h1E47; mbeIn = 1'b1; rbeIn = 1'b1;
    issue(3'd4, 1'b1, 1'b0, 5, mkExp(4, 8'd248, "R5 extended call"), 0);
    chk("R5 SP-1 not written", mem[253], 4'h6);
    chk("R5 flags at SP-2", mem[252], 4'h3);
    chk("R5 PC[7:4] at SP-3", mem[251], 4'h4);
    chk("R5 PC[3:0] at SP-4", mem[250], 4'h7);
    chk("R5 PC top at SP-5", mem[249], 4'h1);
    chk("R5 PC[11:8] at SP-6", mem[248], 4'hE);
    pcIn = '0; mbeIn = 1'b0; rbeIn = 1'b0;
    e = mkExp(5, 8'd254, "R6 extended return"); e.pc = 14'h1E47; e.mbe = 1'b1; e.rbe = 1'b1;
    issue(3'd5, 1'b1, 1'b0, 5, e, 0);
    e = mkExp(1, 8'd0, "R2 pop pair 3C"); e.pair = 8'h3C;
    issue(3'd1, 1'b0, 1'b0, 2, e, 0);

    // R8: a second command while busy is dropped
    pairIn = 8'h5A;
    issue(3'd0, 1'b0, 1'b0, 2, mkExp(0, 8'd254, "R8 push with busy command"), 1);
    repeat (3) begin
      @(negedge clk);
      chk("R8 no second command", busy, 0);
    end
    chk("R8 sp after dropped command", sp, 8'd254);
    chk("R8 pair hi stored", mem[255], 4'h5);
    chk("R8 pair lo stored", mem[254], 4'hA);

    // R8: op codes 6 and 7 do nothing
    for (int c = 6; c < 8; c++) begin
      @(negedge clk);
      cmdOp = 3'(c); cmdValid = 1'b1;
      @(negedge clk);
      cmdValid = 1'b0;
      repeat (3) begin
        chk("R8 bad op no busy", busy, 0);
        chk("R8 bad op no access", memEn, 0);
        @(negedge clk);
      end
      chk("R8 bad op sp", sp, 8'd254);
    end

    e = mkExp(1, 8'd0, "R2 pop pair 5A"); e.pair = 8'h5A;
    issue(3'd1, 1'b0, 1'b0, 2, e, 0);
    repeat (2) @(negedge clk);
    chk("R7 every command completed once", q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule